// File: doc/BRIEF.md
# Packet Timestamp Capture Latch

This block freezes the running system time at the moment a packet that needs a timestamp starts, once for the transmit path and once for the receive path. Each direction owns a single 64-bit capture slot and a valid flag. When a slot is valid it is locked: later packets pass unstamped until the upper 32-bit half of the stamp is read, which clears the flag and re-arms the slot. Because only one packet per direction can hold a stamp at a time, a stamp read out always belongs to the most recently captured packet.

On transmit, a packet qualifies when its start-of-packet strobe arrives together with a per-packet stamp request. On receive, qualification comes from header fields already parsed upstream: a layer-2 ethertype match, a UDP destination-port match, the precision-time protocol version and the message-type code. These are judged against a two-bit filter mode and a selected message code. Each direction has its own enable. Clearing an enable drops that direction's valid flag and stops captures.

Top module: `pkt_stamp_latch`

## Requirements
- R1: After reset, both valid flags are 0 and both 64-bit stamps read 0.
- R2: With tx_en high and tx_valid low, a cycle with tx_sop and tx_stamp_req both high loads systime of that cycle into {tx_stamp_hi, tx_stamp_lo} and sets tx_valid, both seen after that clock edge. tx_sop without tx_stamp_req captures nothing.
- R3: While a slot is valid and no high-word read is strobed, further qualifying packets leave its stamp and valid flag unchanged.
- R4: A high-word read strobe (tx_rd_hi / rx_rd_hi) on a valid slot clears valid after that edge. The stamp value is kept, and the next qualifying packet is captured again.
- R5: While a direction's enable is low, its valid flag is cleared after the next edge and no capture takes place.
- R6: Receive mode 0 (layer-4, version 1) qualifies only when rx_is_udp is 1, rx_udp_dport equals rx_sel_port, rx_ptp_v2 is 0 and rx_msg_type equals rx_sel_code.
- R7: Receive mode 1 (version 2, single type) qualifies when rx_ptp_v2 is 1, rx_msg_type equals rx_sel_code, and either rx_ethertype is 0x88F7 or the UDP port match of R6 holds.
- R8: Receive mode 2 (version 2 events) qualifies on the same transport match as R7 with rx_ptp_v2 at 1 and any rx_msg_type from 0 to 3. rx_sel_code is ignored.
- R9: Receive mode 3 qualifies no packet, so rx_valid stays 0.
- R10: The two directions are independent. Capture, release and enable of one never change the other's flag or stamp.
- R11: A read strobe in the same cycle as a qualifying packet on a valid slot releases the slot but does not capture that packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| systime | input | 64 | Running system time |
| tx_en | input | 1 | Transmit capture enable |
| tx_sop | input | 1 | Transmit start-of-packet strobe |
| tx_stamp_req | input | 1 | Packet is marked for stamping |
| tx_rd_hi | input | 1 | Transmit high-word read strobe |
| rx_en | input | 1 | Receive capture enable |
| rx_mode | input | 2 | Receive filter mode (0..3) |
| rx_sel_port | input | 16 | UDP destination port to match |
| rx_sel_code | input | 4 | Message-type code to match |
| rx_sop | input | 1 | Receive start-of-packet strobe |
| rx_ethertype | input | 16 | Parsed ethertype |
| rx_is_udp | input | 1 | Packet carries UDP |
| rx_udp_dport | input | 16 | Parsed UDP destination port |
| rx_ptp_v2 | input | 1 | 1 = protocol version 2, 0 = version 1 |
| rx_msg_type | input | 4 | Parsed message-type code |
| rx_rd_hi | input | 1 | Receive high-word read strobe |
| tx_valid | output | 1 | Transmit stamp held |
| tx_stamp_lo | output | 32 | Transmit stamp, low half |
| tx_stamp_hi | output | 32 | Transmit stamp, high half |
| rx_valid | output | 1 | Receive stamp held |
| rx_stamp_lo | output | 32 | Receive stamp, low half |
| rx_stamp_hi | output | 32 | Receive stamp, high half |

## Verification
The hardest case to reach is a read strobe and a qualifying packet meeting a locked slot in the same cycle, because the release must win and the packet must be lost. Random traffic rarely lines these up, so a directed step places them together on purpose. A second step has the next packet arrive one cycle later to show that the slot re-arms. Filter modes are reached by walking each mode with packets that differ from a match in only one field: version, port, ethertype or message code. Random traffic biased toward port 319, ethertype 0x88F7 and low message codes then mixes enables, reads and modes, and a bench model tracks both slots.

// File: rtl/ts_pkg.sv
package ts_pkg;
  typedef enum logic [1:0] {
    RXM_V1_UDP   = 2'd0,
    RXM_V2_ONE   = 2'd1,
    RXM_V2_EVENT = 2'd2,
    RXM_OFF      = 2'd3
  } rx_mode_e;

  localparam int DIR_TX = 0;
  localparam int DIR_RX = 1;
  localparam int NDIR   = 2;
endpackage

// File: rtl/ts_rx_filter.sv
module ts_rx_filter
  import ts_pkg::*;
#(
  parameter int          ETH_W     = 16,
  parameter int          PORT_W    = 16,
  parameter int          MT_W      = 4,
  parameter logic [15:0] ETH_PTP   = 16'h88F7,
  parameter int          EVENT_CNT = 4
) (
  input  logic              sop,
  input  logic [1:0]        mode,
  input  logic [PORT_W-1:0] sel_port,
  input  logic [MT_W-1:0]   sel_code,
  input  logic [ETH_W-1:0]  ethertype,
  input  logic              is_udp,
  input  logic [PORT_W-1:0] dport,
  input  logic              ptp_v2,
  input  logic [MT_W-1:0]   msg_type,
  output logic              hit
);
  localparam logic [MT_W-1:0] EV_LIM = MT_W'(EVENT_CNT);

  logic l2_ok, l4_ok, code_ok, event_ok;
  rx_mode_e m;

  always_comb begin
    m        = rx_mode_e'(mode);
    l2_ok    = (ethertype == ETH_W'(ETH_PTP));
    l4_ok    = is_udp && (dport == sel_port);
    code_ok  = (msg_type == sel_code);
    event_ok = (msg_type < EV_LIM);
    unique case (m)
      RXM_V1_UDP:   hit = sop && l4_ok && !ptp_v2 && code_ok;
      RXM_V2_ONE:   hit = sop && (l2_ok || l4_ok) && ptp_v2 && code_ok;
      RXM_V2_EVENT: hit = sop && (l2_ok || l4_ok) && ptp_v2 && event_ok;
      default:      hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/ts_stamp_slot.sv
module ts_stamp_slot #(
  parameter int TW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          hit,
  input  logic          rd_hi,
  input  logic [TW-1:0] time_in,
  output logic          valid,
  output logic [TW-1:0] stamp
);
  logic take;
  assign take = en && !valid && hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      stamp <= '0;
    end else begin
      if (!en)                valid <= 1'b0;
      else if (valid && rd_hi) valid <= 1'b0;
      else if (take)           valid <= 1'b1;
      if (take) stamp <= time_in;
    end
  end

  // R2: a capture takes the time of the qualifying cycle
  a_r2_capture: assert property (@(posedge clk) disable iff (rst)
    (en && !valid && hit) |=> (valid && stamp == $past(time_in)));
  // R3: a locked slot holds its value
  a_r3_locked: assert property (@(posedge clk) disable iff (rst)
    (en && valid && !rd_hi) |=> (valid && $stable(stamp)));
  // R4: reading the high word releases
  a_r4_release: assert property (@(posedge clk) disable iff (rst)
    (en && valid && rd_hi) |=> !valid);
  // R5: disabled slot never holds a stamp
  a_r5_disabled: assert property (@(posedge clk) disable iff (rst)
    !en |=> !valid);
  // R11: release cycle drops a coincident packet
  a_r11_no_take: assert property (@(posedge clk) disable iff (rst)
    (valid && rd_hi && hit) |=> $stable(stamp));
endmodule

// File: rtl/pkt_stamp_latch.sv
module pkt_stamp_latch
  import ts_pkg::*;
#(
  parameter int          TIME_W  = 64,
  parameter int          ETH_W   = 16,
  parameter int          PORT_W  = 16,
  parameter int          MT_W    = 4,
  parameter logic [15:0] ETH_PTP = 16'h88F7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [TIME_W-1:0]    systime,
  input  logic                 tx_en,
  input  logic                 tx_sop,
  input  logic                 tx_stamp_req,
  input  logic                 tx_rd_hi,
  input  logic                 rx_en,
  input  logic [1:0]           rx_mode,
  input  logic [PORT_W-1:0]    rx_sel_port,
  input  logic [MT_W-1:0]      rx_sel_code,
  input  logic                 rx_sop,
  input  logic [ETH_W-1:0]     rx_ethertype,
  input  logic                 rx_is_udp,
  input  logic [PORT_W-1:0]    rx_udp_dport,
  input  logic                 rx_ptp_v2,
  input  logic [MT_W-1:0]      rx_msg_type,
  input  logic                 rx_rd_hi,
  output logic                 tx_valid,
  output logic [TIME_W/2-1:0]  tx_stamp_lo,
  output logic [TIME_W/2-1:0]  tx_stamp_hi,
  output logic                 rx_valid,
  output logic [TIME_W/2-1:0]  rx_stamp_lo,
  output logic [TIME_W/2-1:0]  rx_stamp_hi
);
  localparam int HALF = TIME_W / 2;

  logic              en_v    [NDIR];
  logic              hit_v   [NDIR];
  logic              rd_v    [NDIR];
  logic              valid_v [NDIR];
  logic [TIME_W-1:0] stamp_v [NDIR];
  logic              rx_hit;

  ts_rx_filter #(
    .ETH_W(ETH_W), .PORT_W(PORT_W), .MT_W(MT_W), .ETH_PTP(ETH_PTP), .EVENT_CNT(4)
  ) u_filter (
    .sop(rx_sop), .mode(rx_mode), .sel_port(rx_sel_port), .sel_code(rx_sel_code),
    .ethertype(rx_ethertype), .is_udp(rx_is_udp), .dport(rx_udp_dport),
    .ptp_v2(rx_ptp_v2), .msg_type(rx_msg_type), .hit(rx_hit)
  );

  assign en_v[DIR_TX]  = tx_en;
  assign hit_v[DIR_TX] = tx_sop && tx_stamp_req;
  assign rd_v[DIR_TX]  = tx_rd_hi;
  assign en_v[DIR_RX]  = rx_en;
  assign hit_v[DIR_RX] = rx_hit;
  assign rd_v[DIR_RX]  = rx_rd_hi;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    ts_stamp_slot #(.TW(TIME_W)) u_slot (
      .clk(clk), .rst(rst), .en(en_v[d]), .hit(hit_v[d]), .rd_hi(rd_v[d]),
      .time_in(systime), .valid(valid_v[d]), .stamp(stamp_v[d])
    );
  end

  assign tx_valid    = valid_v[DIR_TX];
  assign tx_stamp_lo = stamp_v[DIR_TX][HALF-1:0];
  assign tx_stamp_hi = stamp_v[DIR_TX][TIME_W-1:HALF];
  assign rx_valid    = valid_v[DIR_RX];
  assign rx_stamp_lo = stamp_v[DIR_RX][HALF-1:0];
  assign rx_stamp_hi = stamp_v[DIR_RX][TIME_W-1:HALF];

  // R9: filter off mode never produces a receive stamp
  a_r9_mode_off: assert property (@(posedge clk) disable iff (rst)
    (rx_mode == 2'd3 && !rx_valid) |=> !rx_valid);
  // R10: receive traffic alone leaves the transmit stamp alone
  a_r10_tx_isolated: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_en && !tx_rd_hi) |=> ($stable(tx_stamp_lo) && $stable(tx_stamp_hi)));
endmodule

// File: tb/sim_pkt_stamp_latch.sv
module sim_pkt_stamp_latch;
  logic clk = 0, rst = 1;
  logic [63:0] systime = 64'h0000_0001_0000_0000;
  logic tx_en = 1, tx_sop = 0, tx_stamp_req = 0, tx_rd_hi = 0;
  logic rx_en = 1, rx_sop = 0, rx_is_udp = 0, rx_ptp_v2 = 0, rx_rd_hi = 0;
  logic [1:0]  rx_mode = 2'd1;
  logic [15:0] rx_sel_port = 16'd319, rx_ethertype = 0, rx_udp_dport = 0;
  logic [3:0]  rx_sel_code = 0, rx_msg_type = 0;
  logic tx_valid, rx_valid;
  logic [31:0] tx_stamp_lo, tx_stamp_hi, rx_stamp_lo, rx_stamp_hi;

  int checks = 0, errors = 0;
  bit done = 0;
  bit m_valid [2];
  logic [63:0] m_stamp [2];

  always #10 clk = ~clk;

  pkt_stamp_latch u0 (
    .clk(clk), .rst(rst), .systime(systime),
    .tx_en(tx_en), .tx_sop(tx_sop), .tx_stamp_req(tx_stamp_req), .tx_rd_hi(tx_rd_hi),
    .rx_en(rx_en), .rx_mode(rx_mode), .rx_sel_port(rx_sel_port), .rx_sel_code(rx_sel_code),
    .rx_sop(rx_sop), .rx_ethertype(rx_ethertype), .rx_is_udp(rx_is_udp),
    .rx_udp_dport(rx_udp_dport), .rx_ptp_v2(rx_ptp_v2), .rx_msg_type(rx_msg_type),
    .rx_rd_hi(rx_rd_hi),
    .tx_valid(tx_valid), .tx_stamp_lo(tx_stamp_lo), .tx_stamp_hi(tx_stamp_hi),
    .rx_valid(rx_valid), .rx_stamp_lo(rx_stamp_lo), .rx_stamp_hi(rx_stamp_hi)
  );

  function automatic bit exp_hit();
    bit l2, l4;
    l2 = (rx_ethertype == 16'h88F7);
    l4 = rx_is_udp && (rx_udp_dport == rx_sel_port);
    if (!rx_sop) return 0;
    case (rx_mode)
      2'd0: return l4 && !rx_ptp_v2 && (rx_msg_type == rx_sel_code);
      2'd1: return (l2 || l4) && rx_ptp_v2 && (rx_msg_type == rx_sel_code);
      2'd2: return (l2 || l4) && rx_ptp_v2 && (rx_msg_type < 4);
      default: return 0;
    endcase
  endfunction

  task automatic upd(input int d, input bit en, input bit hit, input bit rd);
    if (!en) m_valid[d] = 0;
    else if (m_valid[d] && rd) m_valid[d] = 0;
    else if (!m_valid[d] && hit) begin
      m_valid[d] = 1;
      m_stamp[d] = systime;
    end
  endtask

  task automatic cmp(input int d, input string tag);
    bit v;
    logic [63:0] s;
    v = (d == 0) ? tx_valid : rx_valid;
    s = (d == 0) ? {tx_stamp_hi, tx_stamp_lo} : {rx_stamp_hi, rx_stamp_lo};
    checks++;
    if (v !== m_valid[d] || s !== m_stamp[d]) begin
      errors++;
      $display("FAIL %s dir=%0d actual valid=%0b stamp=%h expected valid=%0b stamp=%h",
               tag, d, v, s, m_valid[d], m_stamp[d]);
    end
  endtask

  task automatic tick(input string tag);
    bit rh;
    rh = exp_hit();
    upd(0, tx_en, tx_sop && tx_stamp_req, tx_rd_hi);
    upd(1, rx_en, rh, rx_rd_hi);
    @(posedge clk);
    @(negedge clk);
    cmp(0, tag);
    cmp(1, tag);
    tx_sop = 0; tx_stamp_req = 0; tx_rd_hi = 0; rx_sop = 0; rx_rd_hi = 0;
    systime = systime + 64'd1 + 64'($urandom % 50);
  endtask

  task automatic rx_pkt(input logic [15:0] eth, input bit udp, input logic [15:0] dp,
                        input bit v2, input logic [3:0] mt);
    rx_ethertype = eth; rx_is_udp = udp; rx_udp_dport = dp;
    rx_ptp_v2 = v2; rx_msg_type = mt; rx_sop = 1;
  endtask

  task automatic rx_release(input string tag);
    rx_rd_hi = 1;
    tick(tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1588));
    m_valid[0] = 0; m_valid[1] = 0; m_stamp[0] = 0; m_stamp[1] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    cmp(0, "R1 reset");
    cmp(1, "R1 reset");

    tx_sop = 1; tx_stamp_req = 1; tick("R2 tx capture");
    tx_sop = 1; tx_stamp_req = 1; tick("R3 locked");
    tick("R10 rx idle while tx held");
    tx_rd_hi = 1; tick("R4 release");
    tx_sop = 1; tx_stamp_req = 1; tick("R4 re-arm");
    tx_rd_hi = 1; tx_sop = 1; tx_stamp_req = 1; tick("R11 read with packet");
    tx_sop = 1; tx_stamp_req = 1; tick("R11 next packet");
    tx_en = 0; tick("R5 disable");
    tx_sop = 1; tx_stamp_req = 1; tick("R5 no capture");
    tx_en = 1;
    tx_sop = 1; tick("R2 unmarked packet");

    rx_mode = 2'd0; rx_sel_code = 4'd0;
    rx_pkt(16'h0800, 1, 16'd319, 0, 4'd0); tick("R6 v1 udp match");
    rx_release("R4 rx release");
    rx_pkt(16'h0800, 1, 16'd319, 1, 4'd0); tick("R6 v2 rejected");
    rx_pkt(16'h88F7, 0, 16'd0, 0, 4'd0);   tick("R6 l2 rejected");
    rx_pkt(16'h0800, 1, 16'd319, 0, 4'd1); tick("R6 code rejected");

    rx_mode = 2'd1; rx_sel_code = 4'd1;
    rx_pkt(16'h88F7, 0, 16'd0, 1, 4'd1); tick("R7 l2 match");
    rx_release("R7 release");
    rx_pkt(16'h0800, 1, 16'd319, 1, 4'd1); tick("R7 udp match");
    rx_release("R7 release");
    rx_pkt(16'h88F7, 0, 16'd0, 1, 4'd2);   tick("R7 code rejected");
    rx_pkt(16'h0800, 1, 16'd320, 1, 4'd1); tick("R7 port rejected");

    rx_mode = 2'd2; rx_sel_code = 4'd9;
    rx_pkt(16'h88F7, 0, 16'd0, 1, 4'd3); tick("R8 event 3");
    rx_release("R8 release");
    rx_pkt(16'h88F7, 0, 16'd0, 1, 4'd8); tick("R8 general rejected");
    rx_pkt(16'h0800, 1, 16'd319, 1, 4'd0); tick("R8 event 0");
    rx_release("R8 release");

    rx_mode = 2'd3; rx_sel_code = 4'd1;
    rx_pkt(16'h88F7, 1, 16'd319, 1, 4'd1); tick("R9 off");
    rx_pkt(16'h88F7, 1, 16'd319, 0, 4'd1); tick("R9 off");

    for (int i = 0; i < 800; i++) begin
      tx_en = ($urandom % 8) != 0;
      rx_en = ($urandom % 8) != 0;
      tx_sop = $urandom % 2; tx_stamp_req = $urandom % 2;
      tx_rd_hi = ($urandom % 4) == 0;
      rx_rd_hi = ($urandom % 4) == 0;
      rx_mode = 2'($urandom % 4);
      rx_sel_code = 4'($urandom % 5);
      rx_sel_port = ($urandom % 4 != 0) ? 16'd319 : 16'd320;
      rx_pkt(($urandom % 2) ? 16'h88F7 : 16'h0800, $urandom % 2,
             ($urandom % 3 != 0) ? 16'd319 : 16'($urandom),
             $urandom % 2, 4'($urandom % 6));
      rx_sop = $urandom % 2;
      tick("R10 random traffic");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule